// File: doc/BRIEF.md
# SPI Transfer CRC Engine

This block runs alongside the shift register of an SPI port and computes two cyclic redundancy checks in parallel. One covers the bits sent on the transmit line and the other covers the bits sampled from the receive line. Both use one programmable generator polynomial. The shifter reports each shifted bit through a bit strobe and marks frame boundaries with start and end strobes. The block tracks both checksums bit by bit, and both values are visible on its outputs at all times. Frames are 8 or 16 bits wide, and the CRC width follows the frame width. Bits are taken most significant first.

When software issues the CRC-next command, or the DMA path signals its last frame, the sequencer marks a later frame as the CRC frame. During that frame the shifter sends `crc_word`, a snapshot of the transmit CRC, in place of buffer data. The frame received at the same time is treated as the incoming CRC. When the CRC frame ends, the receive calculator has absorbed that frame. Any non-zero remainder sets a sticky error flag, which software clears by writing zero.

The sequencer has four states. IDLE is the rest state. WAIT_LAST is used only in receive-only mode and lets one more data frame pass. ARMED waits for the next frame start. CRC_FRAME covers the frame that carries the checksum. The transitions are as follows:
- IDLE goes to ARMED on a command when full duplex is selected.
- IDLE goes to WAIT_LAST on a command when receive-only is selected.
- WAIT_LAST goes to ARMED on frame end.
- ARMED goes to CRC_FRAME on frame start, and the snapshot is taken at that point.
- CRC_FRAME goes to IDLE on frame end, and the check is made at that point.
- Dropping the enable returns any state to IDLE.

Top module: `spi_crc_engine`

## Requirements
- R1: After reset `tx_crc`, `rx_crc` and `crc_word` are 0. `crc_err` and `crc_frame` are 0. `poly_q` holds the reset polynomial 16'h0007.
- R2: On each cycle with `bit_stb` high and `crc_en` high, each calculator takes one step, using `tx_bit` for the transmit side and `rx_bit` for the receive side. A step computes fb = bit XOR crc[top], then crc = ((crc << 1) XOR (fb ? poly : 0)) masked to the width. The new value appears on the port after that clock edge. Without `bit_stb` the values do not change.
- R3: `poly_wr` loads `poly_wdata` into the single polynomial register, which is shown on `poly_q`. Both calculators use it. In 8-bit mode only poly[7:0] is used.
- R4: While `crc_en` is low, both calculators are held at 0, the sequencer stays in IDLE, and commands have no effect.
- R5: `wide`=1 selects 16-bit frames and CRCs. `wide`=0 selects 8-bit frames and CRCs, the top bit is bit 7, and bits 15:8 of both CRCs stay 0.
- R6: In full duplex (`rx_only`=0), a `crc_next` pulse makes the next frame the CRC frame. `crc_frame` is high from the cycle after `frame_start` until the cycle after `frame_end`. `crc_word` holds the transmit CRC as it was at that `frame_start`.
- R7: In receive-only mode (`rx_only`=1), after a `crc_next` pulse one more frame passes as data with `crc_frame` low, and the frame after it is the CRC frame.
- R8: With `dma_mode`=1, a `dma_last` pulse acts as the command without `crc_next`. With `dma_mode`=0, `dma_last` is ignored.
- R9: At `frame_end` of the CRC frame, `crc_err` is set if the receive CRC, having absorbed that frame, is non-zero. If it is zero, `crc_err` is not set.
- R10: `crc_err` stays set until `err_wr` with `err_wdata`=0. `err_wr` with `err_wdata`=1 leaves it unchanged.
- R11: After the CRC frame ends, frames are plain data frames again, with `crc_frame` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crc_en | input | 1 | CRC enable; low clears both calculators |
| wide | input | 1 | 1 selects 16-bit frames, 0 selects 8-bit frames |
| rx_only | input | 1 | Receive-only timing for the CRC command |
| dma_mode | input | 1 | Allows `dma_last` to act as the command |
| poly_wr | input | 1 | Polynomial write strobe |
| poly_wdata | input | 16 | Polynomial write data |
| crc_next | input | 1 | Software CRC-next command pulse |
| dma_last | input | 1 | Last DMA frame written pulse |
| err_wr | input | 1 | Error flag write strobe |
| err_wdata | input | 1 | Error flag write data; 0 clears the flag |
| bit_stb | input | 1 | One bit shifted this cycle |
| tx_bit | input | 1 | Bit sent on the line |
| rx_bit | input | 1 | Bit sampled from the line |
| frame_start | input | 1 | Frame begins (no bit in this cycle) |
| frame_end | input | 1 | Frame complete (after its last bit) |
| tx_crc | output | 16 | Transmit CRC |
| rx_crc | output | 16 | Receive CRC |
| poly_q | output | 16 | Polynomial register |
| crc_word | output | 16 | Transmit CRC snapshot to shift out |
| crc_frame | output | 1 | Current frame is the CRC frame |
| crc_err | output | 1 | Sticky CRC mismatch flag |

## Verification
The bench feeds random-looking frames in both widths. In 8-bit mode it uses a polynomial with non-zero upper bits, so a design that read the wrong top bit or failed to mask would leak into bits 15:8. It sends a correct and a corrupted received CRC. A design that compared against the pre-frame value, or lost the flag on a later frame or on a write of one, would show the wrong `crc_err`. It also checks the receive-only timing, where a sequencer that skipped WAIT_LAST would mark the last data frame as the CRC frame. Finally it sends `dma_last` with DMA off, which a design that ignored `dma_mode` would treat as a command.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_LAST = 2'd1,
        ST_ARMED     = 2'd2,
        ST_CRC_FRAME = 2'd3
    } crc_state_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/spi_crc_lane.sv
module spi_crc_lane #(
    parameter int unsigned W  = 16,
    parameter int unsigned NW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         upd,
    input  logic         din,
    input  logic         wide,
    input  logic [W-1:0] poly,
    output logic [W-1:0] crc
);

    localparam logic [W-1:0] MASK_N = W'((1 << NW) - 1);

    logic [W-1:0] mask;
    logic         top;
    logic         fb;
    logic [W-1:0] nxt;

    always_comb begin
        mask = wide ? '1 : MASK_N;
        top  = wide ? crc[W-1] : crc[NW-1];
        fb   = top ^ din;
        nxt  = ((crc << 1) ^ (fb ? poly : '0)) & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (upd) begin
            crc <= nxt;
        end
    end

endmodule

// File: rtl/spi_crc_seq.sv
module spi_crc_seq
    import spi_crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic crc_en,
    input  logic rx_only,
    input  logic cmd,
    input  logic frame_start,
    input  logic frame_end,
    output logic in_crc,
    output logic snap_ld,
    output logic chk_stb
);

    crc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!crc_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (cmd) state_d = rx_only ? ST_WAIT_LAST : ST_ARMED;
                ST_WAIT_LAST: if (frame_end) state_d = ST_ARMED;
                ST_ARMED:     if (frame_start) state_d = ST_CRC_FRAME;
                ST_CRC_FRAME: if (frame_end) state_d = ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        in_crc  = 1'b0;
        snap_ld = 1'b0;
        chk_stb = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_WAIT_LAST: ;
            ST_ARMED:     snap_ld = crc_en & frame_start;
            ST_CRC_FRAME: begin
                in_crc  = 1'b1;
                chk_stb = crc_en & frame_end;
            end
            default:      ;
        endcase
    end

endmodule

// File: rtl/spi_crc_engine.sv
module spi_crc_engine
    import spi_crc_pkg::*;
#(
    parameter int unsigned   W        = 16,
    parameter int unsigned   NW       = 8,
    parameter logic [15:0]   POLY_RST = 16'h0007
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          crc_en,
    input  logic          wide,
    input  logic          rx_only,
    input  logic          dma_mode,
    input  logic          poly_wr,
    input  logic [W-1:0]  poly_wdata,
    input  logic          crc_next,
    input  logic          dma_last,
    input  logic          err_wr,
    input  logic          err_wdata,
    input  logic          bit_stb,
    input  logic          tx_bit,
    input  logic          rx_bit,
    input  logic          frame_start,
    input  logic          frame_end,
    output logic [W-1:0]  tx_crc,
    output logic [W-1:0]  rx_crc,
    output logic [W-1:0]  poly_q,
    output logic [W-1:0]  crc_word,
    output logic          crc_frame,
    output logic          crc_err
);

    logic [LANES-1:0]   lane_bit;
    logic [W-1:0]       lane_crc [LANES];
    logic               cmd;
    logic               snap_ld;
    logic               chk_stb;

    assign lane_bit = {rx_bit, tx_bit};
    assign cmd      = crc_en & (crc_next | (dma_mode & dma_last));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poly_q <= W'(POLY_RST);
        end else if (poly_wr) begin
            poly_q <= poly_wdata;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        spi_crc_lane #(.W(W), .NW(NW)) lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (~crc_en),
            .upd   (crc_en & bit_stb),
            .din   (lane_bit[g]),
            .wide  (wide),
            .poly  (poly_q),
            .crc   (lane_crc[g])
        );
    end

    assign tx_crc = lane_crc[0];
    assign rx_crc = lane_crc[1];

    spi_crc_seq seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .crc_en      (crc_en),
        .rx_only     (rx_only),
        .cmd         (cmd),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .in_crc      (crc_frame),
        .snap_ld     (snap_ld),
        .chk_stb     (chk_stb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_word <= '0;
        end else if (snap_ld) begin
            crc_word <= tx_crc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_err <= 1'b0;
        end else if (chk_stb && (rx_crc != '0)) begin
            crc_err <= 1'b1;
        end else if (err_wr && !err_wdata) begin
            crc_err <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_crc_engine_chk.sv
module spi_crc_engine_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         crc_en,
    input logic         bit_stb,
    input logic         frame_start,
    input logic         frame_end,
    input logic         err_wr,
    input logic         err_wdata,
    input logic [W-1:0] tx_crc,
    input logic [W-1:0] rx_crc,
    input logic         crc_frame,
    input logic         crc_err
);

    p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_en && !bit_stb) |=> ($stable(tx_crc) && $stable(rx_crc)));

    p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_en |=> (tx_crc == '0 && rx_crc == '0 && !crc_frame));

    p_frame_begin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_frame) |-> $past(frame_start));

    p_err_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> ($past(frame_end) && $past(crc_frame)));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !(err_wr && !err_wdata)) |=> crc_err);

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wr && !err_wdata && !frame_end) |=> !crc_err);

endmodule

bind spi_crc_engine spi_crc_engine_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .crc_en      (crc_en),
    .bit_stb     (bit_stb),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .err_wr      (err_wr),
    .err_wdata   (err_wdata),
    .tx_crc      (tx_crc),
    .rx_crc      (rx_crc),
    .crc_frame   (crc_frame),
    .crc_err     (crc_err)
);

// File: tb/spi_crc_engine_tb.sv
module spi_crc_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crc_en = 1'b0, wide = 1'b1, rx_only = 1'b0, dma_mode = 1'b0;
    logic        poly_wr = 1'b0;
    logic [15:0] poly_wdata = '0;
    logic        crc_next = 1'b0, dma_last = 1'b0, err_wr = 1'b0, err_wdata = 1'b0;
    logic        bit_stb = 1'b0, tx_bit = 1'b0, rx_bit = 1'b0;
    logic        frame_start = 1'b0, frame_end = 1'b0;
    logic [15:0] tx_crc, rx_crc, poly_q, crc_word;
    logic        crc_frame, crc_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [15:0] m_tx = '0, m_rx = '0, m_poly = 16'h0007;

    always #4 clk = ~clk;

    spi_crc_engine dut_i (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .wide(wide), .rx_only(rx_only),
        .dma_mode(dma_mode), .poly_wr(poly_wr), .poly_wdata(poly_wdata),
        .crc_next(crc_next), .dma_last(dma_last), .err_wr(err_wr), .err_wdata(err_wdata),
        .bit_stb(bit_stb), .tx_bit(tx_bit), .rx_bit(rx_bit),
        .frame_start(frame_start), .frame_end(frame_end),
        .tx_crc(tx_crc), .rx_crc(rx_crc), .poly_q(poly_q), .crc_word(crc_word),
        .crc_frame(crc_frame), .crc_err(crc_err)
    );

    // {wide, poly, tx word, rx word}
    localparam logic [48:0] VEC [6] = '{
        {1'b1, 16'h1021, 16'h1234, 16'hABCD},
        {1'b0, 16'h0007, 16'h00A5, 16'h003C},
        {1'b1, 16'h8005, 16'hFFFF, 16'h0000},
        {1'b0, 16'h0031, 16'h0080, 16'h00FF},
        {1'b1, 16'h0001, 16'h0001, 16'h8000},
        {1'b0, 16'hFFD5, 16'h005A, 16'h0001}
    };

    function automatic logic [15:0] ref_step(logic [15:0] c, logic b, logic [15:0] p, logic w);
        logic fb;
        fb = b ^ (w ? c[15] : c[7]);
        return ((c << 1) ^ (fb ? p : 16'h0)) & (w ? 16'hFFFF : 16'h00FF);
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic restart_crc();
        crc_en = 1'b0; tick(); crc_en = 1'b1;
        m_tx = '0; m_rx = '0;
    endtask

    task automatic write_poly(logic [15:0] p);
        poly_wr = 1'b1; poly_wdata = p; tick(); poly_wr = 1'b0;
        m_poly = p;
    endtask

    // use_crc: send crc_word; rx carries the model rx CRC (flipped LSB if corrupt)
    task automatic send_frame(string req, bit use_crc, bit corrupt, logic [15:0] txw,
                              logic [15:0] rxw, logic exp_cf);
        logic [15:0] t, r;
        int n;
        n = wide ? 16 : 8;
        frame_start = 1'b1; tick(); frame_start = 1'b0;
        chk(req, {15'h0, crc_frame}, {15'h0, exp_cf});
        t = use_crc ? crc_word : txw;
        r = use_crc ? (m_rx ^ {15'h0, corrupt}) : rxw;
        for (int i = n - 1; i >= 0; i--) begin
            bit_stb = 1'b1; tx_bit = t[i]; rx_bit = r[i];
            if (crc_en) begin
                m_tx = ref_step(m_tx, t[i], m_poly, wide);
                m_rx = ref_step(m_rx, r[i], m_poly, wide);
            end
            tick();
        end
        bit_stb = 1'b0;
        frame_end = 1'b1; tick(); frame_end = 1'b0;
    endtask

    task automatic pulse_next();
        crc_next = 1'b1; tick(); crc_next = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] snap;
        repeat (3) tick();
        // R1 reset state
        chk("R1 tx_crc", tx_crc, 16'h0);
        chk("R1 rx_crc", rx_crc, 16'h0);
        chk("R1 poly", poly_q, 16'h0007);
        chk("R1 flags", {14'h0, crc_frame, crc_err}, 16'h0);
        chk("R1 crc_word", crc_word, 16'h0);
        rst_n = 1'b1; tick();

        // table walk: R2 R3 R5 over both widths
        for (int v = 0; v < 6; v++) begin
            wide = VEC[v][48];
            write_poly(VEC[v][47:32]);
            chk("R3 poly readback", poly_q, VEC[v][47:32]);
            restart_crc();
            send_frame("R11 data frame", 1'b0, 1'b0, VEC[v][31:16], VEC[v][15:0], 1'b0);
            chk("R2 tx crc", tx_crc, m_tx);
            chk("R2 rx crc", rx_crc, m_rx);
            if (!wide) chk("R5 narrow upper byte", {tx_crc[15:8], rx_crc[15:8]}, 16'h0);
        end

        // R2 single bit step and stall
        wide = 1'b1; write_poly(16'h1021); restart_crc();
        bit_stb = 1'b1; tx_bit = 1'b1; rx_bit = 1'b0; tick(); bit_stb = 1'b0;
        chk("R2 one bit tx", tx_crc, 16'h1021);
        chk("R2 one bit rx", rx_crc, 16'h0000);
        tx_bit = 1'b0; repeat (3) tick();
        chk("R2 stall tx", tx_crc, 16'h1021);

        // R4 disabled: no updates, command ignored
        crc_en = 1'b0; tick();
        chk("R4 cleared", tx_crc, 16'h0);
        pulse_next();
        send_frame("R4 no crc frame", 1'b0, 1'b0, 16'hBEEF, 16'h1357, 1'b0);
        chk("R4 tx held", tx_crc, 16'h0);
        chk("R4 rx held", rx_crc, 16'h0);

        // R6 R9 full duplex, correct CRC
        restart_crc();
        send_frame("R6 data", 1'b0, 1'b0, 16'hC0DE, 16'hC0DE, 1'b0);
        snap = m_tx;
        pulse_next();
        send_frame("R6 crc frame flag", 1'b1, 1'b0, 16'h0, 16'h0, 1'b1);
        chk("R6 crc_word snapshot", crc_word, snap);
        chk("R11 flag drops", {15'h0, crc_frame}, 16'h0);
        chk("R9 match residue", rx_crc, 16'h0);
        chk("R9 no error", {15'h0, crc_err}, 16'h0);

        // R9 R10 corrupted CRC in 8-bit mode
        wide = 1'b0; write_poly(16'h0007); restart_crc();
        send_frame("R9 data", 1'b0, 1'b0, 16'h0042, 16'h0017, 1'b0);
        pulse_next();
        send_frame("R9 crc frame", 1'b1, 1'b1, 16'h0, 16'h0, 1'b1);
        chk("R9 error set", {15'h0, crc_err}, 16'h1);
        send_frame("R11 data after crc", 1'b0, 1'b0, 16'h0011, 16'h0022, 1'b0);
        chk("R10 sticky", {15'h0, crc_err}, 16'h1);
        err_wr = 1'b1; err_wdata = 1'b1; tick(); err_wr = 1'b0;
        chk("R10 write one", {15'h0, crc_err}, 16'h1);
        err_wr = 1'b1; err_wdata = 1'b0; tick(); err_wr = 1'b0;
        chk("R10 write zero", {15'h0, crc_err}, 16'h0);

        // R7 receive-only timing
        wide = 1'b1; rx_only = 1'b1; restart_crc();
        send_frame("R7 first", 1'b0, 1'b0, 16'h0, 16'h5A5A, 1'b0);
        pulse_next();
        send_frame("R7 last data", 1'b0, 1'b0, 16'h0, 16'h0F0F, 1'b0);
        send_frame("R7 crc frame", 1'b1, 1'b0, 16'h0, 16'h0, 1'b1);
        chk("R7 residue", rx_crc, 16'h0);
        chk("R7 no error", {15'h0, crc_err}, 16'h0);
        rx_only = 1'b0;

        // R8 DMA trigger
        restart_crc();
        dma_last = 1'b1; tick(); dma_last = 1'b0;
        send_frame("R8 dma off ignored", 1'b0, 1'b0, 16'h1111, 16'h1111, 1'b0);
        dma_mode = 1'b1;
        dma_last = 1'b1; tick(); dma_last = 1'b0;
        send_frame("R8 dma crc frame", 1'b1, 1'b0, 16'h0, 16'h0, 1'b1);
        chk("R8 residue", rx_crc, 16'h0);
        dma_mode = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule